// File: doc/BRIEF.md
# Power-Aware Interrupt Target Selector

This block decides which processor core should take a re-routable interrupt. For every core it receives an eligibility bit, the core's current idle depth as a 3-bit C-state code, and a flag that says whether the core is asking for a turbo operating point. A single mode input sets the bias. In power bias the block avoids waking a sleeping core. In performance bias it avoids adding work to a core that is already running.

When a request strobe is sampled, the block compares all eligible cores in one combinational pass and registers the result. The chosen core index appears one cycle later together with a valid pulse. If no core is eligible, an error pulse appears in place of the valid pulse and the index is forced to zero. Between requests the index output keeps its last value.

Top module: `irq_target_sel`

## Requirements
- R1: Only a core whose bit is set in `elig_i` can be reported on `core_o` with `valid_o` high.
- R2: With `power_bias_i`=1 the eligible core with the smallest C-state code is chosen, so a core in C0 is chosen over any core in a deeper state. `cstate_i` bits [3i+2:3i] hold the code of core i: 0 is C0, and a larger value is a deeper state.
- R3: With `power_bias_i`=1, among eligible cores that share the smallest code, a core with its `turbo_i` bit at 0 is chosen over a core requesting turbo. Any remaining tie goes to the lowest index.
- R4: With `power_bias_i`=0, if any eligible core has a nonzero code, the eligible core with the smallest nonzero code is chosen, even when eligible cores in C0 exist.
- R5: With `power_bias_i`=0 and every eligible core in C0, the lowest-index eligible core that is not requesting turbo is chosen. If all of them request turbo, the lowest-index eligible core is chosen.
- R6: With `power_bias_i`=0, among eligible idle cores that share the smallest nonzero code, a non-turbo core is chosen first, then the lowest index.
- R7: A request with `elig_i` all zero gives `err_o`=1, `valid_o`=0 and `core_o`=0 in the next cycle.
- R8: `valid_o` or `err_o` is high exactly in the cycle after a cycle with `req_i` high. The two are never high together, and the result reflects the inputs sampled with the request.
- R9: In a cycle after `req_i` was low, `valid_o` and `err_o` are 0 and `core_o` keeps its previous value, whatever the other inputs did.
- R10: While `rst_n` is low, `valid_o`=0, `err_o`=0 and `core_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Selection request, sampled on the rising edge |
| power_bias_i | input | 1 | 1 = power bias, 0 = performance bias |
| elig_i | input | NUM_CORES | Per-core eligibility for this interrupt |
| cstate_i | input | 3*NUM_CORES | Per-core C-state code, core i at bits [3i+2:3i] |
| turbo_i | input | NUM_CORES | Per-core turbo request |
| valid_o | output | 1 | One-cycle pulse: `core_o` holds a chosen core |
| err_o | output | 1 | One-cycle pulse: the request had no eligible core |
| core_o | output | log2(NUM_CORES) | Index of the chosen core |

## Verification
The selection is combinational from the sampled inputs into a single output register, so a wrong ranking key or a broken tie rule shows up on `core_o` in the very cycle after the request. A faulty clock enable or a bad strobe path shows up in the following cycle: either `core_o` drifts while no request is present, or `valid_o` or `err_o` is high outside the pulse cycle. The bench mixes directed cases with seeded random inputs. Each result is compared with a model that applies the bias rules directly, so every rank order and tie break is hit across both modes.

// File: rtl/irq_target_sel_pkg.sv
package irq_target_sel_pkg;
  localparam int unsigned CST_W  = 3;
  // key = {awake-penalty, cstate, turbo}; smaller key wins
  localparam int unsigned RANK_W = CST_W + 2;

  typedef logic [RANK_W-1:0] rank_t;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_core_rank.sv
module irq_core_rank
  import irq_target_sel_pkg::*;
(
  input  logic             power_bias_i,
  input  logic [CST_W-1:0] cstate_i,
  input  logic             turbo_i,
  output rank_t            rank_o
);
  logic awake;

  always_comb begin
    awake = (cstate_i == '0);
    if (power_bias_i) begin
      // shallowest first, non-turbo before turbo
      rank_o = {1'b0, cstate_i, turbo_i};
    end else begin
      // any idle core ranks ahead of every awake core
      rank_o = {awake, cstate_i, turbo_i};
    end
  end
endmodule

// File: rtl/irq_rank_argmin.sv
module irq_rank_argmin
  import irq_target_sel_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  localparam int unsigned IDX_W = idx_width(NUM_CORES)
) (
  input  rank_t            rank_i [NUM_CORES],
  input  logic [NUM_CORES-1:0] mask_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             found_o
);
  rank_t            best_rank [NUM_CORES+1];
  logic [IDX_W-1:0] best_idx  [NUM_CORES+1];
  logic             have      [NUM_CORES+1];

  assign best_rank[0] = '0;
  assign best_idx[0]  = '0;
  assign have[0]      = 1'b0;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_stage
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    logic take;
    // strict compare keeps the lower index on equal rank
    assign take = mask_i[g] && (!have[g] || (rank_i[g] < best_rank[g]));
    assign best_rank[g+1] = take ? rank_i[g] : best_rank[g];
    assign best_idx[g+1]  = take ? MY_IDX    : best_idx[g];
    assign have[g+1]      = have[g] || mask_i[g];
  end

  assign idx_o   = have[NUM_CORES] ? best_idx[NUM_CORES] : '0;
  assign found_o = have[NUM_CORES];

  always_comb begin
    if (found_o) begin
      a_found_eligible_r1 : assert (mask_i[idx_o])
        else $error("argmin picked a masked-out core");
    end
  end
endmodule

// File: rtl/irq_target_sel.sv
module irq_target_sel
  import irq_target_sel_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  localparam int unsigned IDX_W = idx_width(NUM_CORES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_i,
  input  logic                       power_bias_i,
  input  logic [NUM_CORES-1:0]       elig_i,
  input  logic [CST_W*NUM_CORES-1:0] cstate_i,
  input  logic [NUM_CORES-1:0]       turbo_i,
  output logic                       valid_o,
  output logic                       err_o,
  output logic [IDX_W-1:0]           core_o
);
  rank_t            rank [NUM_CORES];
  logic [IDX_W-1:0] win_idx;
  logic             win_found;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_rank
    irq_core_rank u_rank (
      .power_bias_i (power_bias_i),
      .cstate_i     (cstate_i[g*CST_W +: CST_W]),
      .turbo_i      (turbo_i[g]),
      .rank_o       (rank[g])
    );
  end

  irq_rank_argmin #(.NUM_CORES(NUM_CORES)) u_argmin (
    .rank_i  (rank),
    .mask_i  (elig_i),
    .idx_o   (win_idx),
    .found_o (win_found)
  );

  // next state
  logic             valid_d, err_d, core_en;
  logic [IDX_W-1:0] core_d;

  always_comb begin
    core_en = req_i;
    valid_d = req_i &&  win_found;
    err_d   = req_i && !win_found;
    core_d  = win_found ? win_idx : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= valid_d;
      err_o   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_o <= '0;
    end else if (core_en) begin
      core_o <= core_d;
    end
  end

  // checks
  p_pick_eligible_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && (elig_i != '0)) |=> (valid_o && ((($past(elig_i) >> core_o) & NUM_CORES'(1)) != '0)))
    else $error("chosen core was not eligible");

  p_none_error_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && (elig_i == '0)) |=> (err_o && !valid_o && (core_o == '0)))
    else $error("empty eligibility not flagged");

  p_exclusive_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && err_o))
    else $error("valid and error together");

  p_idle_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!valid_o && !err_o && $stable(core_o)))
    else $error("output moved without a request");
endmodule

// File: tb/irq_target_sel_bench.sv
module irq_target_sel_bench;
  localparam int N  = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_i = 1'b0;
  logic          power_bias_i = 1'b0;
  logic [N-1:0]  elig_i = '0;
  logic [3*N-1:0] cstate_i = '0;
  logic [N-1:0]  turbo_i = '0;
  logic          valid_o, err_o;
  logic [IW-1:0] core_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_target_sel u_irq_target_sel (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .power_bias_i(power_bias_i),
    .elig_i(elig_i), .cstate_i(cstate_i), .turbo_i(turbo_i),
    .valid_o(valid_o), .err_o(err_o), .core_o(core_o)
  );

  // pick among a candidate set: non-turbo first, then lowest index
  function automatic int pick_in(input logic [N-1:0] cand, input logic [N-1:0] tb);
    for (int i = 0; i < N; i++) if (cand[i] && !tb[i]) return i;
    for (int i = 0; i < N; i++) if (cand[i]) return i;
    return -1;
  endfunction

  function automatic int model(input logic pb, input logic [N-1:0] el,
                               input logic [3*N-1:0] cs, input logic [N-1:0] tb);
    int best = 8;
    logic [N-1:0] cand = '0;
    if (el == '0) return -1;
    for (int i = 0; i < N; i++) begin
      int c = int'(cs[3*i +: 3]);
      if (el[i] && (pb || c != 0) && c < best) best = c;
    end
    if (best == 8) best = 0;  // performance bias, every eligible core awake
    for (int i = 0; i < N; i++)
      if (el[i] && int'(cs[3*i +: 3]) == best) cand[i] = 1'b1;
    return pick_in(cand, tb);
  endfunction

  task automatic check(input string tag, input logic v, input logic e, input int c,
                       input logic ev, input logic ee, input int ec);
    checks++;
    if (v !== ev || e !== ee || c != ec) begin
      errors++;
      $display("FAIL %s: valid=%0b err=%0b core=%0d expected valid=%0b err=%0b core=%0d",
               tag, v, e, c, ev, ee, ec);
    end
  endtask

  // drive one request at a negedge, check at the next negedge
  task automatic run_req(input string tag, input logic pb, input logic [N-1:0] el,
                         input logic [3*N-1:0] cs, input logic [N-1:0] tb);
    int exp;
    power_bias_i = pb; elig_i = el; cstate_i = cs; turbo_i = tb; req_i = 1'b1;
    exp = model(pb, el, cs, tb);
    @(negedge clk);
    req_i = 1'b0;
    if (exp < 0) check(tag, valid_o, err_o, int'(core_o), 1'b0, 1'b1, 0);
    else         check(tag, valid_o, err_o, int'(core_o), 1'b1, 1'b0, exp);
  endtask

  function automatic logic [3*N-1:0] cs4(input int c3, input int c2, input int c1, input int c0);
    return {3'(c3), 3'(c2), 3'(c1), 3'(c0)};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int prev;
    void'($urandom(32'd1234));
    @(negedge clk);
    check("R10 reset", valid_o, err_o, int'(core_o), 1'b0, 1'b0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // power bias
    run_req("R2 C0 over C6",        1'b1, 4'b0011, cs4(0,0,0,6), 4'b0000);
    run_req("R2 shallowest deep",   1'b1, 4'b1110, cs4(3,6,1,0), 4'b0000);
    run_req("R1 ineligible C0",     1'b1, 4'b1010, cs4(6,0,3,0), 4'b0000);
    run_req("R3 nonturbo tie",      1'b1, 4'b1111, cs4(0,0,0,0), 4'b0011);
    run_req("R3 all turbo lowest",  1'b1, 4'b1100, cs4(0,0,0,0), 4'b1111);
    // performance bias
    run_req("R4 wake C6 over C0",   1'b0, 4'b0011, cs4(0,0,6,0), 4'b0000);
    run_req("R4 shallowest idle",   1'b0, 4'b1111, cs4(6,3,0,1), 4'b0000);
    run_req("R5 all C0 nonturbo",   1'b0, 4'b1111, cs4(0,0,0,0), 4'b0011);
    run_req("R5 all C0 all turbo",  1'b0, 4'b0110, cs4(0,0,0,0), 4'b1111);
    run_req("R6 idle tie nonturbo", 1'b0, 4'b1111, cs4(3,3,0,3), 4'b0001);
    run_req("R6 idle tie index",    1'b0, 4'b1110, cs4(6,6,6,0), 4'b0000);
    // no eligible
    run_req("R7 none eligible",     1'b1, 4'b0000, cs4(0,0,0,0), 4'b0000);
    run_req("R7 none eligible perf",1'b0, 4'b0000, cs4(6,6,6,6), 4'b1111);

    // R9 hold without request
    run_req("R8 setup", 1'b1, 4'b1000, cs4(0,6,6,6), 4'b0000);
    prev = int'(core_o);
    power_bias_i = 1'b0; elig_i = 4'b0001; cstate_i = cs4(0,0,0,6); turbo_i = '0;
    @(negedge clk);
    check("R9 hold", valid_o, err_o, int'(core_o), 1'b0, 1'b0, prev);
    @(negedge clk);
    check("R9 hold again", valid_o, err_o, int'(core_o), 1'b0, 1'b0, prev);

    // R8 back-to-back requests
    power_bias_i = 1'b1; elig_i = 4'b0100; cstate_i = '0; turbo_i = '0; req_i = 1'b1;
    @(negedge clk);
    check("R8 b2b first", valid_o, err_o, int'(core_o), 1'b1, 1'b0, 2);
    elig_i = 4'b0010;
    @(negedge clk);
    req_i = 1'b0;
    check("R8 b2b second", valid_o, err_o, int'(core_o), 1'b1, 1'b0, 1);

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic          pb = 1'($urandom());
      logic [N-1:0]  el = N'($urandom());
      logic [3*N-1:0] cs;
      logic [N-1:0]  tb = N'($urandom());
      for (int i = 0; i < N; i++) begin
        int r = int'($urandom_range(0, 3));
        cs[3*i +: 3] = (r == 0) ? 3'd0 : (r == 1) ? 3'd1 : (r == 2) ? 3'd3 : 3'd6;
      end
      run_req(pb ? "R2 R3 random power" : "R4 R5 R6 random perf", pb, el, cs, tb);
      if (($urandom() & 3) == 0) begin
        prev = int'(core_o);
        elig_i = ~elig_i;
        @(negedge clk);
        check("R9 random idle", valid_o, err_o, int'(core_o), 1'b0, 1'b0, prev);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule